// File: doc/BRIEF.md
# Blocking Fetch-Execute Sequencer

This block is the control sequencer of a small non-pipelined processor that runs one instruction at a time. From its running state it puts a fetch request on an instruction port and waits for the reply. When the reply arrives, the instruction either finishes on the spot or starts exactly one load or store on a separate data port, and the block waits for that reply as well. Only then does the next fetch begin.

Both memory ports use a request/accept handshake within a single cycle. If a port refuses a request, the sequencer copies the request into a holding register and parks in a retry state. It resends the copy only when that port pulses its retry strobe, and that resend counts as accepted. A fault reported during fetch setup or data address setup sends nothing to memory: the program counter jumps to a fixed fault target and the next fetch follows. Activate, suspend and switch-out commands gate the sequencer. A suspend that arrives during an instruction takes effect at the next instruction boundary.

Decode is limited to a stub that reads a few fields of the instruction word. Translation and memory live outside the block. Responses are never back-pressured.

Top module: `fx_sequencer`

## Requirements
- R1: After a synchronous reset the state code is Idle (0), the program counter is RESET_PC (default 0x100), the protocol-error flag, retire and acknowledge outputs are low, and neither port has a request.
- R2: An activate command in Idle (0) moves the state to Running (1). The first fetch request appears D cycles after the cycle that follows the activate edge, where D is the delay input. An activate command in any other state is ignored.
- R3: A fetch request carries the program counter. If the instruction port accepts it in the same cycle, the state becomes instruction-wait (3). If the port refuses it, the state becomes instruction-retry (2) and the address is held. No request is raised while the block waits for a retry.
- R4: An instruction retry strobe in state 2 drives the held address on the fetch request in that same cycle, and the state moves to 3.
- R5: The instruction word encodes its kind in bits [1:0]: 0 compute, 1 load, 2 store, 3 prefetch. An instruction response in state 3 for a compute or prefetch word raises no data request. The program counter then advances by 4, and the state returns to Running.
- R6: An instruction response for a load or store raises a data request in the same cycle. The request carries the address from bits [31:16] zero-extended, the write flag (high for store), the write data (the instruction's own program counter, zero-extended) and the size code from bits [3:2] (0/1/2/3 mean 1/2/4/8 bytes). If the data port accepts, the state becomes data-wait (5). If it refuses, the state becomes data-retry (4), and a data retry strobe resends the held request and moves to 5.
- R7: A data response in state 5 completes the instruction: the program counter advances by 4 and the state returns to Running (1).
- R8: A fetch fault at fetch issue, or a data fault with a load or store response, raises no request on the port concerned. The program counter becomes FAULT_PC (default 0x80), the state is Running, and fetching continues from there.
- R9: A suspend in Running moves to Idle at once and no fetch is issued. A suspend in states 2 to 5 leaves the current instruction running. When that instruction completes the state goes to Idle, and no further fetch follows.
- R10: A switch-out command in Running moves the state to switched-out (6), which holds until reset. In every state the acknowledge output pulses high for one cycle, one cycle after the command.
- R11: A response or retry strobe that arrives in a state other than the one expecting it sets a sticky protocol-error flag and leaves the state unchanged.
- R12: The retire output pulses once for every completed instruction, whether it completed normally or through a fault, and the program counter never changes without a retire pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| activate_i | input | 1 | Start command, honoured in Idle |
| delay_i | input | DLY_W | Cycles to wait before the first fetch |
| suspend_i | input | 1 | Stop at the next instruction boundary |
| swout_i | input | 1 | Switch-out command |
| sw_ack_o | output | 1 | Switch-out acknowledge pulse |
| fetch_fault_i | input | 1 | Fetch setup fault from translation stub |
| if_req_o | output | 1 | Instruction port request |
| if_addr_o | output | ADDR_W | Fetch address |
| if_acc_i | input | 1 | Instruction port accepts the request this cycle |
| if_retry_i | input | 1 | Instruction port retry strobe |
| if_rsp_i | input | 1 | Instruction response valid |
| if_rdata_i | input | INSN_W | Instruction word |
| d_fault_i | input | 1 | Data address fault from translation stub |
| d_req_o | output | 1 | Data port request |
| d_addr_o | output | ADDR_W | Data address |
| d_we_o | output | 1 | Write flag |
| d_wdata_o | output | DATA_W | Write data |
| d_size_o | output | 2 | Access size code |
| d_acc_i | input | 1 | Data port accepts the request this cycle |
| d_retry_i | input | 1 | Data port retry strobe |
| d_rsp_i | input | 1 | Data response valid |
| state_o | output | 3 | Current state code |
| pc_o | output | ADDR_W | Program counter |
| retire_o | output | 1 | Instruction completed pulse |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
A wrong state register shows up quickly at the ports. Within one cycle a request either appears where none belongs or fails to appear after a retry strobe, and the state code exposes the mismatch on the next edge. A corrupted holding register shows as a wrong address on the resend, in the cycle of the strobe. A wrong completion path shows in the program counter and the retire pulse on the edge after the response. The random phase drives every combination of refusal, fault and response delay and tracks the expected program counter instruction by instruction.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_IRETRY = 3'd2,
    ST_IWAIT  = 3'd3,
    ST_DRETRY = 3'd4,
    ST_DWAIT  = 3'd5,
    ST_SWOUT  = 3'd6
  } fxs_state_e;

  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_PREF  = 2'd3
  } fxs_kind_e;

endpackage

// File: rtl/fxs_hold.sv
module fxs_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  // R3, R6
  hold_set_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (valid_o && data_o == $past(data_i)));

  // R4, R6
  hold_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !load_i) |=> !valid_o);

endmodule

// File: rtl/fxs_delay.sv
module fxs_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load_i)                  cnt_q <= value_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  dly_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && dec_i && !zero_o) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/fxs_decode.sv
module fxs_decode
  import fxs_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int ADDR_W = 32,
  parameter int AF_LSB = 16
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic              is_mem_o,
  output logic              is_store_o,
  output logic [1:0]        size_o,
  output logic [ADDR_W-1:0] addr_o
);

  fxs_kind_e kind;
  logic      unused_bits;

  assign kind        = fxs_kind_e'(insn_i[1:0]);
  assign is_mem_o    = (kind == K_LOAD) || (kind == K_STORE);
  assign is_store_o  = (kind == K_STORE);
  assign size_o      = insn_i[3:2];
  assign addr_o      = ADDR_W'(insn_i[INSN_W-1:AF_LSB]);
  assign unused_bits = ^insn_i[AF_LSB-1:4];

endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fxs_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                INSN_W      = 32,
  parameter int                DATA_W      = 64,
  parameter int                DLY_W       = 8,
  parameter int                INSN_BYTES  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC    = 'h100,
  parameter logic [ADDR_W-1:0] FAULT_PC    = 'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              activate_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              suspend_i,
  input  logic              swout_i,
  output logic              sw_ack_o,
  input  logic              fetch_fault_i,
  output logic              if_req_o,
  output logic [ADDR_W-1:0] if_addr_o,
  input  logic              if_acc_i,
  input  logic              if_retry_i,
  input  logic              if_rsp_i,
  input  logic [INSN_W-1:0] if_rdata_i,
  input  logic              d_fault_i,
  output logic              d_req_o,
  output logic [ADDR_W-1:0] d_addr_o,
  output logic              d_we_o,
  output logic [DATA_W-1:0] d_wdata_o,
  output logic [1:0]        d_size_o,
  input  logic              d_acc_i,
  input  logic              d_retry_i,
  input  logic              d_rsp_i,
  output logic [2:0]        state_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              retire_o,
  output logic              proto_err_o
);

  localparam int DP_W = ADDR_W + 1 + DATA_W + 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  fxs_state_e        state_q, state_d, bnd_st;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              retire_q, err_q, ack_q, stop_pend_q, stop_pend_d;

  // ---------------- sub-blocks ----------------
  logic              cnt_zero;
  logic              dec_mem, dec_store;
  logic [1:0]        dec_size;
  logic [ADDR_W-1:0] dec_addr;
  logic              i_hold_v, d_hold_v;
  logic [ADDR_W-1:0] i_hold_q;
  logic [DP_W-1:0]   d_hold_q, d_new;

  logic in_run, fetch_slot, fetch_issue, fetch_flt, i_retry_ok, irsp_ok;
  logic mem_op, d_issue, d_flt, d_retry_ok, drsp_ok, done_seq, done_flt, bad;

  fxs_delay #(.W(DLY_W)) u_delay (
    .clk(clk), .rst(rst),
    .load_i (state_q == ST_IDLE && activate_i),
    .value_i(delay_i),
    .dec_i  (in_run),
    .zero_o (cnt_zero)
  );

  fxs_decode #(.INSN_W(INSN_W), .ADDR_W(ADDR_W), .AF_LSB(16)) u_dec (
    .insn_i(if_rdata_i), .is_mem_o(dec_mem), .is_store_o(dec_store),
    .size_o(dec_size), .addr_o(dec_addr)
  );

  fxs_hold #(.W(ADDR_W)) u_ihold (
    .clk(clk), .rst(rst),
    .load_i (fetch_issue && !if_acc_i),
    .clear_i(i_retry_ok),
    .data_i (pc_q),
    .valid_o(i_hold_v), .data_o(i_hold_q)
  );

  fxs_hold #(.W(DP_W)) u_dhold (
    .clk(clk), .rst(rst),
    .load_i (d_issue && !d_acc_i),
    .clear_i(d_retry_ok),
    .data_i (d_new),
    .valid_o(d_hold_v), .data_o(d_hold_q)
  );

  // ---------------- handshake decode ----------------
  assign in_run      = (state_q == ST_RUN);
  assign fetch_slot  = in_run && cnt_zero && !swout_i && !suspend_i;
  assign fetch_issue = fetch_slot && !fetch_fault_i;
  assign fetch_flt   = fetch_slot && fetch_fault_i;
  assign i_retry_ok  = (state_q == ST_IRETRY) && if_retry_i;
  assign irsp_ok     = (state_q == ST_IWAIT) && if_rsp_i;
  assign mem_op      = irsp_ok && dec_mem;
  assign d_issue     = mem_op && !d_fault_i;
  assign d_flt       = mem_op && d_fault_i;
  assign d_retry_ok  = (state_q == ST_DRETRY) && d_retry_i;
  assign drsp_ok     = (state_q == ST_DWAIT) && d_rsp_i;
  assign done_seq    = (irsp_ok && !dec_mem) || drsp_ok;
  assign done_flt    = fetch_flt || d_flt;
  assign bnd_st      = (stop_pend_q || suspend_i) ? ST_IDLE : ST_RUN;

  assign bad = (if_rsp_i   && state_q != ST_IWAIT)  ||
               (if_retry_i && state_q != ST_IRETRY) ||
               (d_rsp_i    && state_q != ST_DWAIT)  ||
               (d_retry_i  && state_q != ST_DRETRY);

  assign if_req_o  = fetch_issue || i_retry_ok;
  assign if_addr_o = i_retry_ok ? i_hold_q : pc_q;

  assign d_new   = {dec_addr, dec_store, DATA_W'(pc_q), dec_size};
  assign d_req_o = d_issue || d_retry_ok;
  assign {d_addr_o, d_we_o, d_wdata_o, d_size_o} = d_retry_ok ? d_hold_q : d_new;

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (activate_i) state_d = ST_RUN;
      ST_RUN: begin
        if (swout_i)               state_d = ST_SWOUT;
        else if (suspend_i)        state_d = ST_IDLE;
        else if (fetch_issue)      state_d = if_acc_i ? ST_IWAIT : ST_IRETRY;
      end
      ST_IRETRY: if (if_retry_i) state_d = ST_IWAIT;
      ST_IWAIT: begin
        if (if_rsp_i) begin
          if (!dec_mem || d_fault_i) state_d = bnd_st;
          else                       state_d = d_acc_i ? ST_DWAIT : ST_DRETRY;
        end
      end
      ST_DRETRY: if (d_retry_i) state_d = ST_DWAIT;
      ST_DWAIT:  if (d_rsp_i)   state_d = bnd_st;
      ST_SWOUT:  state_d = ST_SWOUT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pc_d = pc_q;
    if (done_flt)      pc_d = FAULT_PC;
    else if (done_seq) pc_d = pc_q + STEP;
  end

  always_comb begin
    if (state_d == ST_IDLE || state_d == ST_RUN || state_d == ST_SWOUT)
      stop_pend_d = 1'b0;
    else
      stop_pend_d = stop_pend_q || suspend_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pc_q        <= RESET_PC;
      retire_q    <= 1'b0;
      err_q       <= 1'b0;
      ack_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      pc_q        <= pc_d;
      retire_q    <= done_seq || done_flt;
      err_q       <= err_q || bad;
      ack_q       <= swout_i;
      stop_pend_q <= stop_pend_d;
    end
  end

  assign state_o     = state_q;
  assign pc_o        = pc_q;
  assign retire_o    = retire_q;
  assign proto_err_o = err_q;
  assign sw_ack_o    = ack_q;

  // ---------------- assertions ----------------
  // R3
  ihold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IRETRY) == i_hold_v);

  // R6
  dhold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRETRY) == d_hold_v);

  // R4
  iretry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IRETRY && if_retry_i) |=> (state_q == ST_IWAIT));

  // R9
  suspend_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && suspend_i && !swout_i) |=> (state_q == ST_IDLE));

  // R10
  swack_chk: assert property (@(posedge clk) disable iff (rst)
    swout_i |=> sw_ack_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> proto_err_o);

  // R11
  err_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (d_rsp_i && state_q != ST_DWAIT) |=> proto_err_o);

  // R12
  pc_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_q != $past(pc_q)) |-> retire_o);

  // R8
  fault_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_slot && fetch_fault_i) |=> (pc_q == FAULT_PC && state_q == ST_RUN));

endmodule

// File: tb/tb_fx_sequencer.sv
module tb_fx_sequencer;
  localparam int CLK_P = 10;
  localparam logic [31:0] RST_PC = 32'h100;
  localparam logic [31:0] FLT_PC = 32'h80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        activate_i = 0, suspend_i = 0, swout_i = 0, fetch_fault_i = 0;
  logic [7:0]  delay_i = 0;
  logic        if_acc_i = 0, if_retry_i = 0, if_rsp_i = 0;
  logic [31:0] if_rdata_i = 0;
  logic        d_fault_i = 0, d_acc_i = 0, d_retry_i = 0, d_rsp_i = 0;
  logic        sw_ack_o, if_req_o, d_req_o, d_we_o, retire_o, proto_err_o;
  logic [31:0] if_addr_o, d_addr_o, pc_o;
  logic [63:0] d_wdata_o;
  logic [1:0]  d_size_o;
  logic [2:0]  state_o;

  int n_chk = 0, n_bad = 0, ret_seen = 0, exp_ret = 0, seen = 0;
  logic [31:0] exp_pc;
  logic        finished = 0;

  always #(CLK_P/2) clk = ~clk;

  fx_sequencer dut (
    .clk(clk), .rst(rst), .activate_i(activate_i), .delay_i(delay_i),
    .suspend_i(suspend_i), .swout_i(swout_i), .sw_ack_o(sw_ack_o),
    .fetch_fault_i(fetch_fault_i), .if_req_o(if_req_o), .if_addr_o(if_addr_o),
    .if_acc_i(if_acc_i), .if_retry_i(if_retry_i), .if_rsp_i(if_rsp_i),
    .if_rdata_i(if_rdata_i), .d_fault_i(d_fault_i), .d_req_o(d_req_o),
    .d_addr_o(d_addr_o), .d_we_o(d_we_o), .d_wdata_o(d_wdata_o),
    .d_size_o(d_size_o), .d_acc_i(d_acc_i), .d_retry_i(d_retry_i),
    .d_rsp_i(d_rsp_i), .state_o(state_o), .pc_o(pc_o), .retire_o(retire_o),
    .proto_err_o(proto_err_o)
  );

  always @(negedge clk) if (!rst && retire_o) ret_seen++;

  function automatic logic [31:0] mk(input logic [1:0] kind, input logic [1:0] sz,
                                     input logic [15:0] a);
    return {a, 12'h000, sz, kind};
  endfunction

  function automatic logic is_mem(input logic [1:0] kind);
    return (kind == 2'd1) || (kind == 2'd2);
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic nx();
    @(posedge clk); #1;
    activate_i = 0; suspend_i = 0; swout_i = 0; fetch_fault_i = 0;
    if_acc_i = 0; if_retry_i = 0; if_rsp_i = 0;
    d_fault_i = 0; d_acc_i = 0; d_retry_i = 0; d_rsp_i = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic done_ok(input string rq);
    chk({rq, " pc"}, pc_o, exp_pc);
    chk({rq, " retire"}, retire_o, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    exp_pc = RST_PC;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 pc", pc_o, RST_PC);
    chk("R1 err", proto_err_o, 0);
    chk("R1 retire", retire_o, 0);
    chk("R1 ack", sw_ack_o, 0);
    chk("R1 if_req", if_req_o, 0);
    chk("R1 d_req", d_req_o, 0);

    // R2 activate with delay 3
    activate_i = 1; delay_i = 3; nx();
    chk("R2 running", state_o, 1);
    seen = 0; if_acc_i = 1; #1;
    while (!if_req_o && seen < 20) begin nx(); if_acc_i = 1; #1; seen++; end
    chk("R2 delay", seen, 3);
    chk("R3 fetch addr", if_addr_o, exp_pc);
    nx();
    chk("R3 accepted", state_o, 3);
    activate_i = 1; nx();
    chk("R2 ignored when busy", state_o, 3);

    // R5 compute
    if_rsp_i = 1; if_rdata_i = mk(2'd0, 2'd0, 16'h5555); #1;
    chk("R5 no d_req", d_req_o, 0);
    nx(); exp_pc += 4; exp_ret++;
    done_ok("R5"); chk("R5 state", state_o, 1);

    // R3/R4 refused fetch
    if_acc_i = 0; #1;
    chk("R3 req", if_req_o, 1);
    nx(); chk("R3 retry state", state_o, 2);
    nx(); nx();
    chk("R3 parked", state_o, 2); chk("R3 no req while parked", if_req_o, 0);
    if_retry_i = 1; #1;
    chk("R4 resend", if_req_o, 1); chk("R4 held addr", if_addr_o, exp_pc);
    nx(); chk("R4 wait", state_o, 3);

    // R6 load refused then retried
    if_rsp_i = 1; if_rdata_i = mk(2'd1, 2'd2, 16'h1234); d_acc_i = 0; #1;
    chk("R6 d_req", d_req_o, 1); chk("R6 addr", d_addr_o, 32'h1234);
    chk("R6 we", d_we_o, 0); chk("R6 size", d_size_o, 2);
    nx(); chk("R6 dretry", state_o, 4);
    nx(); chk("R6 no d_req parked", d_req_o, 0);
    d_retry_i = 1; #1;
    chk("R6 resend", d_req_o, 1); chk("R6 held addr", d_addr_o, 32'h1234);
    chk("R6 held size", d_size_o, 2);
    nx(); chk("R6 dwait", state_o, 5);
    d_rsp_i = 1; nx(); exp_pc += 4; exp_ret++;
    done_ok("R7"); chk("R7 state", state_o, 1);

    // R6 store accepted
    if_acc_i = 1; #1; nx();
    if_rsp_i = 1; if_rdata_i = mk(2'd2, 2'd3, 16'hABCD); d_acc_i = 1; #1;
    chk("R6 store we", d_we_o, 1); chk("R6 store size", d_size_o, 3);
    chk("R6 store wdata", d_wdata_o, {32'h0, exp_pc});
    nx(); chk("R6 store wait", state_o, 5);
    nx(); chk("R7 still waiting", state_o, 5);
    d_rsp_i = 1; nx(); exp_pc += 4; exp_ret++;
    done_ok("R7 store");

    // R5 prefetch
    if_acc_i = 1; #1; nx();
    if_rsp_i = 1; if_rdata_i = mk(2'd3, 2'd3, 16'h0777); d_acc_i = 1; #1;
    chk("R5 prefetch no d_req", d_req_o, 0);
    nx(); exp_pc += 4; exp_ret++;
    done_ok("R5 prefetch"); chk("R5 prefetch state", state_o, 1);

    // R8 data fault
    if_acc_i = 1; #1; nx();
    if_rsp_i = 1; if_rdata_i = mk(2'd1, 2'd1, 16'h0042); d_fault_i = 1; d_acc_i = 1; #1;
    chk("R8 no d_req", d_req_o, 0);
    nx(); exp_pc = FLT_PC; exp_ret++;
    done_ok("R8 data"); chk("R8 state", state_o, 1);

    // R8 fetch fault
    fetch_fault_i = 1; if_acc_i = 1; #1;
    chk("R8 no if_req", if_req_o, 0);
    nx(); exp_ret++;
    done_ok("R8 fetch"); chk("R8 fetch state", state_o, 1);
    if_acc_i = 1; #1;
    chk("R8 refetch addr", if_addr_o, FLT_PC);
    nx(); chk("R8 refetch wait", state_o, 3);

    // R9 suspend mid-instruction
    suspend_i = 1; nx();
    chk("R9 busy keeps going", state_o, 3);
    if_rsp_i = 1; if_rdata_i = mk(2'd0, 2'd0, 16'h0); nx();
    exp_pc += 4; exp_ret++;
    done_ok("R9"); chk("R9 idle at boundary", state_o, 0);
    nx(); chk("R9 no fetch", if_req_o, 0); chk("R9 stays idle", state_o, 0);

    // R10 switch-out while idle
    swout_i = 1; nx();
    chk("R10 ack idle", sw_ack_o, 1); chk("R10 idle kept", state_o, 0);
    nx(); chk("R10 ack one cycle", sw_ack_o, 0);

    // R9 suspend in Running
    activate_i = 1; delay_i = 5; nx();
    chk("R2 running again", state_o, 1);
    suspend_i = 1; #1; chk("R9 no req", if_req_o, 0);
    nx(); chk("R9 run to idle", state_o, 0);

    // R10 switch-out in Running
    activate_i = 1; delay_i = 4; nx();
    swout_i = 1; nx();
    chk("R10 switched", state_o, 6); chk("R10 ack", sw_ack_o, 1);
    activate_i = 1; nx();
    chk("R10 holds", state_o, 6); chk("R10 ack low", sw_ack_o, 0);

    // R11 protocol errors
    rst = 1; nx(); nx(); rst = 0; exp_pc = RST_PC;
    chk("R11 clear after reset", proto_err_o, 0);
    if_rsp_i = 1; nx();
    chk("R11 stray rsp", proto_err_o, 1); chk("R11 state kept", state_o, 0);
    nx(); chk("R11 sticky", proto_err_o, 1);
    rst = 1; nx(); nx(); rst = 0;
    activate_i = 1; delay_i = 0; nx();
    if_acc_i = 1; #1; nx();
    d_retry_i = 1; nx();
    chk("R11 stray retry", proto_err_o, 1); chk("R11 wait kept", state_o, 3);
    if_rsp_i = 1; if_rdata_i = mk(2'd0, 2'd0, 16'h0); nx();
    exp_pc += 4; exp_ret++;
    done_ok("R5 resume");

    // random phase
    for (int n = 0; n < 250; n++) begin
      logic ff, acc, df, dacc;
      logic [31:0] insn;
      ff = ($urandom % 8) == 0; acc = $urandom % 2;
      fetch_fault_i = ff; if_acc_i = acc; #1;
      chk("R3 rnd req", if_req_o, !ff);
      if (!ff) chk("R3 rnd addr", if_addr_o, exp_pc);
      nx();
      if (ff) begin
        exp_pc = FLT_PC; exp_ret++; done_ok("R8 rnd"); continue;
      end
      if (!acc) begin
        chk("R3 rnd retry", state_o, 2);
        repeat ($urandom % 3) nx();
        if_retry_i = 1; #1;
        chk("R4 rnd addr", if_addr_o, exp_pc);
        nx();
      end
      chk("R4 rnd wait", state_o, 3);
      repeat ($urandom % 3) nx();
      insn = $urandom; df = ($urandom % 8) == 0; dacc = $urandom % 2;
      if_rsp_i = 1; if_rdata_i = insn; d_fault_i = df; d_acc_i = dacc; #1;
      chk("R6 rnd d_req", d_req_o, is_mem(insn[1:0]) && !df);
      if (d_req_o) begin
        chk("R6 rnd addr", d_addr_o, {16'h0, insn[31:16]});
        chk("R6 rnd we", d_we_o, insn[1:0] == 2'd2);
        chk("R6 rnd size", d_size_o, insn[3:2]);
        chk("R6 rnd wdata", d_wdata_o, {32'h0, exp_pc});
      end
      nx();
      if (!is_mem(insn[1:0])) begin
        exp_pc += 4; exp_ret++; done_ok("R5 rnd");
      end else if (df) begin
        exp_pc = FLT_PC; exp_ret++; done_ok("R8 rnd data");
      end else begin
        if (!dacc) begin
          chk("R6 rnd dretry", state_o, 4);
          repeat ($urandom % 3) nx();
          d_retry_i = 1; #1;
          chk("R6 rnd resend", d_addr_o, {16'h0, insn[31:16]});
          nx();
        end
        chk("R6 rnd dwait", state_o, 5);
        repeat ($urandom % 3) nx();
        d_rsp_i = 1; nx();
        exp_pc += 4; exp_ret++; done_ok("R7 rnd");
      end
      chk("R7 rnd running", state_o, 1);
    end

    nx();
    chk("R12 retire count", ret_seen, exp_ret);
    finished = 1;
    summary();
  end

endmodule